// File: doc/BRIEF.md
# Leaky Accumulator Averaging Filter

A streaming smoothing filter for unsigned converter samples. It keeps one running accumulator. Each accepted sample first removes one N-th of the accumulator's present value, truncated, and then adds the new sample. The smoothed result is the updated accumulator scaled down by N. N is a power of two, set by the parameter `LOG2N`, so both divisions are plain right shifts. No window of past samples is stored.

The response behaves like a single-pole RC low-pass stage with a time constant of N sample periods. A step at the input settles along a decaying-exponential curve. The block is meant to damp noise and jitter on slow signals such as supply rails or sensor readings. It adds no resolution: the output has the same width as the input.

Samples arrive with a valid strobe. Each accepted sample produces exactly one result, with its own strobe, one clock later. Between results the output holds its last value.

Top module: `leaky_avg_filter`

## Requirements
- R1: A synchronous active-high `rst` clears the accumulator, drives `avg_valid` low and sets `avg_data` to 0. The first sample accepted after reset is averaged against an empty accumulator.
- R2: `avg_valid` is high in the clock cycle that directly follows each cycle with `smp_valid` high, and low in every other cycle.
- R3: When `smp_valid` is high, the accumulator S becomes S − floor(S / 2^LOG2N) + `smp_data`. When `smp_valid` is low, S keeps its value.
- R4: Each result equals floor(S_new / 2^LOG2N), where S_new is the updated accumulator. With LOG2N = 2, a first sample of 1000 after reset gives 250.
- R5: The accumulator is DATA_W + LOG2N bits wide and never wraps. A long run of full-scale samples (all ones) settles at a full-scale output.
- R6: For a constant input x applied after reset, the outputs never decrease and settle exactly at x.
- R7: While `avg_valid` is low, `avg_data` keeps its previous value.
- R8: When the input steps from full scale down to 0, the outputs never increase and settle at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | A new sample is present on `smp_data` |
| smp_data | input | DATA_W | Unsigned input sample |
| avg_valid | output | 1 | A new smoothed result is present |
| avg_data | output | DATA_W | Smoothed result, S / 2^LOG2N |

## Verification
The assertions check these properties on every cycle:
- the one-cycle strobe relation between input and output;
- that the accumulator is frozen while no sample arrives;
- that the output holds between results;
- that each result is the accumulator scaled down;
- that the accumulator never falls when the new sample is at least the current average, which is how a wrap would show;
- the reset state.

Only the bench scenarios can show the values themselves:
- exact agreement with an independent model along rising and falling step responses;
- the monotonic settling shape;
- convergence to exactly the applied constant, including full scale;
- correct behaviour across idle gaps and a reset in mid-stream.

// File: rtl/leaky_avg_pkg.sv
package leaky_avg_pkg;

  // Accumulator width needed so that N * full-scale plus truncation slack fits.
  function automatic int unsigned acc_width(input int unsigned data_w,
                                            input int unsigned log2n);
    return data_w + log2n;
  endfunction

endpackage

// File: rtl/leaky_acc_core.sv
module leaky_acc_core
  import leaky_avg_pkg::*;
#(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned LOG2N  = 2,
  localparam int unsigned ACC_W = acc_width(DATA_W, LOG2N)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd,
  input  logic [DATA_W-1:0] x_in,
  output logic [ACC_W-1:0]  acc_q,
  output logic [ACC_W-1:0]  acc_next
);

  // One leak-and-add step: drop the truncated N-th, add the new sample.
  function automatic logic [ACC_W-1:0] leak_update(input logic [ACC_W-1:0] s,
                                                   input logic [DATA_W-1:0] x);
    logic [ACC_W-1:0] leak;
    leak = s >> LOG2N;
    return s - leak + ACC_W'(x);
  endfunction

  assign acc_next = leak_update(acc_q, x_in);

  always_ff @(posedge clk) begin
    if (rst)      acc_q <= '0;
    else if (upd) acc_q <= acc_next;
  end

endmodule

// File: rtl/leaky_out_stage.sv
module leaky_out_stage
  import leaky_avg_pkg::*;
#(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned LOG2N  = 2,
  localparam int unsigned ACC_W = acc_width(DATA_W, LOG2N)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ACC_W-1:0]  acc_in,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);

  logic [DATA_W-1:0] scaled;

  // Divide by N: either a straight copy (N = 1) or the upper slice.
  generate
    if (LOG2N == 0) begin : g_unity
      assign scaled = acc_in;
    end else begin : g_shift
      assign scaled = acc_in[ACC_W-1:LOG2N];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= load;
      if (load) out_data <= scaled;
    end
  end

endmodule

// File: rtl/leaky_avg_filter.sv
module leaky_avg_filter
  import leaky_avg_pkg::*;
#(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned LOG2N  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  output logic              avg_valid,
  output logic [DATA_W-1:0] avg_data
);

  localparam int unsigned ACC_W = acc_width(DATA_W, LOG2N);

  // Named internal events, visible to the bound checker.
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_next;
  logic             take_sample;

  assign take_sample = smp_valid;

  leaky_acc_core #(.DATA_W(DATA_W), .LOG2N(LOG2N)) core_i (
    .clk      (clk),
    .rst      (rst),
    .upd      (take_sample),
    .x_in     (smp_data),
    .acc_q    (acc_q),
    .acc_next (acc_next)
  );

  leaky_out_stage #(.DATA_W(DATA_W), .LOG2N(LOG2N)) out_i (
    .clk       (clk),
    .rst       (rst),
    .load      (take_sample),
    .acc_in    (acc_next),
    .out_valid (avg_valid),
    .out_data  (avg_data)
  );

endmodule

// File: rtl/leaky_avg_filter_chk.sv
module leaky_avg_filter_chk
  import leaky_avg_pkg::*;
#(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned LOG2N  = 2,
  localparam int unsigned ACC_W = acc_width(DATA_W, LOG2N)
) (
  input logic              clk,
  input logic              rst,
  input logic              smp_valid,
  input logic [DATA_W-1:0] smp_data,
  input logic              avg_valid,
  input logic [DATA_W-1:0] avg_data,
  input logic [ACC_W-1:0]  acc_q
);

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (acc_q == '0 && !avg_valid && avg_data == '0));

  p_valid_follows_r2: assert property (@(posedge clk) disable iff (rst)
    smp_valid |=> avg_valid);

  p_no_spurious_valid_r2: assert property (@(posedge clk) disable iff (rst)
    !smp_valid |=> !avg_valid);

  p_acc_frozen_r3: assert property (@(posedge clk) disable iff (rst)
    !smp_valid |=> $stable(acc_q));

  p_out_scaled_r4: assert property (@(posedge clk) disable iff (rst)
    avg_valid |-> (ACC_W'(avg_data) == (acc_q >> LOG2N)));

  // A sample at or above the current average must not lower the accumulator.
  // A wrap of the accumulator would break this.
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && (ACC_W'(smp_data) >= (acc_q >> LOG2N))) |=> (acc_q >= $past(acc_q)));

  p_hold_output_r7: assert property (@(posedge clk) disable iff (rst)
    !avg_valid |-> $stable(avg_data));

endmodule

bind leaky_avg_filter leaky_avg_filter_chk #(.DATA_W(DATA_W), .LOG2N(LOG2N)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .smp_valid (smp_valid),
  .smp_data  (smp_data),
  .avg_valid (avg_valid),
  .avg_data  (avg_data),
  .acc_q     (acc_q)
);

// File: tb/leaky_avg_filter_tb_top.sv
module leaky_avg_filter_tb_top;

  localparam int DW = 12;
  localparam int LG = 2;
  localparam int NN = 1 << LG;
  localparam int FULL = (1 << DW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          smp_valid = 1'b0;
  logic [DW-1:0] smp_data = '0;
  logic          avg_valid;
  logic [DW-1:0] avg_data;

  int n_checks = 0;
  int n_fails  = 0;
  int model_s  = 0;
  int last_out = 0;

  always #10 clk = ~clk;

  leaky_avg_filter #(.DATA_W(DW), .LOG2N(LG)) dut_i (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
    .avg_valid(avg_valid), .avg_data(avg_data)
  );

  task automatic chk(input string req, input int actual, input int expected);
    n_checks++;
    if (actual != expected) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
  endtask

  // R1: apply reset and check the cleared state.
  task automatic do_reset();
    rst = 1'b1;
    smp_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 valid after reset", int'(avg_valid), 0);
    chk("R1 data after reset", int'(avg_data), 0);
    rst = 1'b0;
    model_s = 0;
    last_out = 0;
  endtask

  // Present one sample at a negedge and check the result one negedge later.
  task automatic send(input int x);
    smp_valid = 1'b1;
    smp_data = DW'(x);
    model_s = model_s - (model_s / NN) + x;
    @(negedge clk);
    chk("R2 valid after sample", int'(avg_valid), 1);
    chk("R3/R4 averaged value", int'(avg_data), model_s / NN);
    last_out = int'(avg_data);
  endtask

  // R2, R7: idle cycles with no strobe out and a held output.
  task automatic idle(input int cycles);
    smp_valid = 1'b0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      chk("R2 no valid when idle", int'(avg_valid), 0);
      chk("R7 output held", int'(avg_data), last_out);
    end
  endtask

  task automatic t_first_sample();
    do_reset();
    send(1000);
    chk("R4 first result 1000/4", last_out, 250);
    idle(1);
  endtask

  task automatic t_step_up();
    int prev;
    do_reset();
    prev = 0;
    for (int i = 0; i < 40; i++) begin
      send(1000);
      if (last_out < prev) chk("R6 monotonic rise", last_out, prev);
      prev = last_out;
    end
    chk("R6 settles at input", last_out, 1000);
    idle(1);
  endtask

  task automatic t_gaps();
    do_reset();
    send(800);
    idle(3);
    send(800);
    idle(5);
    send(200);
    idle(2);
  endtask

  task automatic t_full_then_down();
    int prev;
    do_reset();
    for (int i = 0; i < 60; i++) send(FULL);
    chk("R5 full scale no wrap", last_out, FULL);
    prev = last_out;
    for (int i = 0; i < 60; i++) begin
      send(0);
      if (last_out > prev) chk("R8 monotonic fall", last_out, prev);
      prev = last_out;
    end
    chk("R8 settles at zero", last_out, 0);
    idle(1);
  endtask

  task automatic t_pattern_and_midreset();
    do_reset();
    for (int i = 0; i < 24; i++) send((i % 3 == 0) ? 3000 : ((i % 3 == 1) ? 17 : 1500));
    idle(1);
    do_reset();
    send(7);
    chk("R1 accumulator cleared by reset", last_out, 1);
    idle(1);
  endtask

  initial begin
    @(negedge clk);
    t_first_sample();
    t_step_up();
    t_gaps();
    t_full_then_down();
    t_pattern_and_midreset();
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL R2 watchdog actual=timeout expected=completion");
    summary();
    $finish;
  end

endmodule